// File: doc/BRIEF.md
# Two-Dimensional Parity Protected Word Memory

This block is a single-port synchronous memory of 64-bit words in which every stored row carries eight interleaved check bits. Check bit p is the XOR of every eighth data bit, starting at bit p. The check bits are used only to notice corruption. Repair comes from a second, orthogonal code: one register row that holds, for each of the 72 stored bit columns, the XOR of that column over all rows. Each write keeps this column row consistent. The write first fetches the old row, then folds both the old and the new row into the column row, so a write costs one extra cycle.

When a read finds a row whose check bits disagree with its data, the block does not answer at once. A recovery sequencer starts from the column row and sweeps the whole array one row per cycle, XORing in every row except the failing one. The result is the original row. The sequencer writes the rebuilt row back in place and presents its data on the response port. If any other row also fails its check during the sweep, the rebuilt value is not trusted. It is not written back, and the response carries an uncorrectable flag. A fault-injection operation XORs a mask into a stored row without touching the column row, so corruption can be produced from the ports.

Top module: `tdp_mem`

## Requirements
- R1: After reset the block clears every row to zero, holding `req_ready` low for exactly WORDS cycles. It then accepts requests, and every row reads back as zero without an error indication.
- R2: A write (`req_op` = 1) stores `req_wdata` at `req_addr`. `req_ready` is low for exactly one cycle after acceptance, and no response is produced.
- R3: Stored row bits [63:0] hold data and bits [71:64] hold check bits. Check bit p (row bit 64+p) is the XOR of data bits p, p+8, …, p+56. As a result, flipping data bit i together with row bit 64+(i mod 8) goes undetected.
- R4: Any burst of 1 to 8 adjacent flipped bits anywhere in a 72-bit row raises `err_detect` when that row is read.
- R5: A read (`req_op` = 0 or 3) of an intact row raises `rsp_valid` with the stored data on the second falling edge after the accepting clock edge. `err_detect` stays low, and `req_ready` returns in the same cycle.
- R6: A read of a row corrupted by such a burst returns the original data on `rsp_data`, and the row is repaired in the array, so the next read of it is clean.
- R7: Recovery holds `fix_busy` high for exactly WORDS+2 cycles, starting in the cycle `err_detect` pulses. `req_ready` is low during that time, and any request presented then is ignored.
- R8: If a second row fails its check during the sweep, `err_uncorr` is raised together with `rsp_valid`, and the failing row is not written back.
- R9: A flip operation (`req_op` = 2) XORs `req_flip` into the stored row at `req_addr` and leaves the column row unchanged. It takes two cycles and produces no response, so applying the same mask twice restores the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_op | input | 2 | 0/3 read, 1 write, 2 flip |
| req_addr | input | AW | Row address |
| req_wdata | input | DW | Write data |
| req_flip | input | DW+PW | XOR mask for the flip operation |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | DW | Read or rebuilt data |
| err_detect | output | 1 | Pulse: a read failed its row check |
| fix_busy | output | 1 | Recovery sweep in progress |
| err_uncorr | output | 1 | With rsp_valid: rebuild not trusted |

## Verification
The hard case is a stored row whose bits disagree with its check code while the column row still matches the intended contents. Ordinary writes can never produce this state, because they always re-encode the row and update the column row. The bench reaches it through the flip operation. It sweeps every burst length from 1 to 8 over every start position in the 72-bit row, then reads the row back to trigger a repair. It also flips paired data and check bits to expose the interleave mapping, and flips two rows at once to force the uncorrectable path before undoing both flips.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_FLIP  = 2'd2,
    OP_READ2 = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_INIT,
    S_IDLE,
    S_ACC,
    S_SWEEP,
    S_FIX,
    S_DONE
  } state_e;
endpackage

// File: rtl/tdp_hcode.sv
module tdp_hcode #(
  parameter int DW = 64,
  parameter int PW = 8
) (
  input  logic [DW-1:0] data_i,
  output logic [PW-1:0] code_o
);
  localparam int TAPS = DW / PW;

  for (genvar p = 0; p < PW; p++) begin : g_bit
    logic [TAPS-1:0] taps;
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      assign taps[k] = data_i[p + k*PW];
    end
    assign code_o[p] = ^taps;
  end
endmodule

// File: rtl/tdp_store.sv
module tdp_store #(
  parameter int WORDS = 16,
  parameter int RW    = 72,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [RW-1:0] wrow,
  input  logic [AW-1:0] raddr,
  output logic [RW-1:0] rrow
);
  logic [RW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wrow;
    rrow <= mem[raddr];
  end
endmodule

// File: rtl/tdp_mem.sv
module tdp_mem
  import tdp_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int DW    = 64,
  parameter int PW    = 8,
  localparam int RW   = DW + PW,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [RW-1:0] req_flip,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          err_detect,
  output logic          fix_busy,
  output logic          err_uncorr
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  state_e        state_q;
  op_e           op_q;
  logic [AW-1:0] addr_q, idx_q;
  logic [DW-1:0] wdata_q;
  logic [RW-1:0] mask_q, vrow_q, acc_q;
  logic          uncorr_q;

  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [RW-1:0] wrow, rd_row, new_row;
  logic [PW-1:0] rd_code, wr_code;
  logic          rd_bad;

  tdp_store #(.WORDS(WORDS), .RW(RW)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wrow(wrow),
    .raddr(raddr), .rrow(rd_row)
  );

  tdp_hcode #(.DW(DW), .PW(PW)) u_chk_rd (.data_i(rd_row[DW-1:0]), .code_o(rd_code));
  tdp_hcode #(.DW(DW), .PW(PW)) u_chk_wr (.data_i(wdata_q), .code_o(wr_code));

  assign rd_bad    = (rd_code != rd_row[RW-1:DW]);
  assign new_row   = {wr_code, wdata_q};
  assign req_ready = (state_q == S_IDLE);
  assign fix_busy  = (state_q == S_SWEEP) || (state_q == S_FIX) || (state_q == S_DONE);

  always_comb begin
    case (state_q)
      S_IDLE:  raddr = req_addr;
      S_SWEEP: raddr = idx_q + AW'(1);
      default: raddr = '0;
    endcase
  end

  always_comb begin
    we    = 1'b0;
    waddr = addr_q;
    wrow  = new_row;
    case (state_q)
      S_INIT: begin
        we    = 1'b1;
        waddr = idx_q;
        wrow  = '0;
      end
      S_ACC: begin
        if (op_q == OP_WRITE) begin
          we = 1'b1;
        end else if (op_q == OP_FLIP) begin
          we   = 1'b1;
          wrow = rd_row ^ mask_q;
        end
      end
      S_FIX: begin
        we   = !uncorr_q;
        wrow = acc_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_INIT;
      op_q       <= OP_READ;
      addr_q     <= '0;
      idx_q      <= '0;
      wdata_q    <= '0;
      mask_q     <= '0;
      vrow_q     <= '0;
      acc_q      <= '0;
      uncorr_q   <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      err_detect <= 1'b0;
      err_uncorr <= 1'b0;
    end else begin
      rsp_valid  <= 1'b0;
      err_detect <= 1'b0;
      err_uncorr <= 1'b0;
      case (state_q)
        S_INIT: begin
          idx_q <= idx_q + AW'(1);
          if (idx_q == LAST) begin
            idx_q   <= '0;
            state_q <= S_IDLE;
          end
        end
        S_IDLE: begin
          if (req_valid) begin
            op_q    <= op_e'(req_op);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_flip;
            state_q <= S_ACC;
          end
        end
        S_ACC: begin
          state_q <= S_IDLE;
          if (op_q == OP_WRITE) begin
            vrow_q <= vrow_q ^ rd_row ^ new_row;
          end else if (op_q != OP_FLIP) begin
            if (rd_bad) begin
              err_detect <= 1'b1;
              acc_q      <= vrow_q;
              uncorr_q   <= 1'b0;
              idx_q      <= '0;
              state_q    <= S_SWEEP;
            end else begin
              rsp_valid <= 1'b1;
              rsp_data  <= rd_row[DW-1:0];
            end
          end
        end
        S_SWEEP: begin
          if (idx_q != addr_q) begin
            acc_q <= acc_q ^ rd_row;
            if (rd_bad) uncorr_q <= 1'b1;
          end
          idx_q <= idx_q + AW'(1);
          if (idx_q == LAST) begin
            idx_q   <= '0;
            state_q <= S_FIX;
          end
        end
        S_FIX: state_q <= S_DONE;
        S_DONE: begin
          rsp_valid  <= 1'b1;
          rsp_data   <= acc_q[DW-1:0];
          err_uncorr <= uncorr_q;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2, R9: every accepted operation stalls the next cycle
  p_accept_stalls_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R7: recovery begins exactly with a detection pulse
  p_detect_in_fix_r7: assert property (@(posedge clk) disable iff (rst)
    err_detect |-> fix_busy);
  p_fix_entry_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(fix_busy) |-> err_detect);

  // R8: the uncorrectable flag only travels with a response
  p_uncorr_with_rsp_r8: assert property (@(posedge clk) disable iff (rst)
    err_uncorr |-> rsp_valid);

  // R5: a response always coincides with the return to idle
  p_rsp_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);
endmodule

// File: tb/test_tdp_mem.sv
module test_tdp_mem;
  localparam int WORDS = 8;
  localparam int DW    = 64;
  localparam int PW    = 8;
  localparam int RW    = DW + PW;
  localparam int AW    = $clog2(WORDS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [RW-1:0] req_flip = '0;
  logic          rsp_valid, err_detect, fix_busy, err_uncorr;
  logic [DW-1:0] rsp_data;

  always #5 clk = ~clk;

  tdp_mem #(.WORDS(WORDS), .DW(DW), .PW(PW)) i_tdp_mem (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_flip(req_flip), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .err_detect(err_detect), .fix_busy(fix_busy), .err_uncorr(err_uncorr)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [DW-1:0] shadow [WORDS];

  int r_lat, r_busy;
  logic r_rsp, r_det, r_unc;
  logic [DW-1:0] r_data;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input int addr,
                       input logic [DW-1:0] wd, input logic [RW-1:0] fm,
                       input bit hold);
    int guard = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = AW'(addr);
    req_wdata = wd; req_flip = fm;
    @(negedge clk);
    if (hold) begin
      req_op = 2'd1; req_wdata = ~wd;
    end else begin
      req_valid = 1'b0;
    end
    r_lat = 1; r_busy = 0; r_rsp = 0; r_det = 0; r_unc = 0; r_data = '0;
    forever begin
      if (fix_busy) r_busy++;
      if (err_detect) r_det = 1'b1;
      if (rsp_valid) begin
        r_rsp = 1'b1; r_data = rsp_data; r_unc = err_uncorr;
      end
      if (req_ready || guard > 1000) break;
      @(negedge clk);
      r_lat++; guard++;
    end
    req_valid = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int pass);
    return (64'(a + 1) * 64'h0123_4567_89AB_CDEF) ^ (64'(pass) * 64'hF0E1_D2C3_B4A5_9687);
  endfunction

  task automatic clean_read(input string tag, input int a);
    do_op(2'd0, a, '0, '0, 1'b0);
    check(tag, "clean read latency", 64'(r_lat), 64'd2);
    check(tag, "clean read data", r_data, shadow[a]);
    check(tag, "clean read flags", {61'd0, r_rsp, r_det, r_unc}, {61'd0, 3'b100});
  endtask

  initial begin
    int lowcnt = 0;
    repeat (3) @(negedge clk);
    check("R1", "outputs in reset", {60'd0, req_ready, rsp_valid, err_detect, fix_busy}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    while (!req_ready && lowcnt < 100) begin lowcnt++; @(negedge clk); end
    // R1: clearing takes WORDS cycles
    check("R1", "init cycles", 64'(lowcnt + 1), 64'(WORDS));
    for (int a = 0; a < WORDS; a++) shadow[a] = '0;
    for (int a = 0; a < WORDS; a++) clean_read("R1", a);

    // R2: two passes so that old contents are nonzero on the second
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < WORDS; a++) begin
        shadow[a] = pat(a, pass);
        do_op(2'd1, a, shadow[a], '0, 1'b0);
        check("R2", "write stall", 64'(r_lat), 64'd2);
        check("R2", "write no response", 64'(r_rsp), 64'd0);
      end
    end
    for (int a = 0; a < WORDS; a++) clean_read("R5", a);

    // R3: paired data/check flips are invisible; R9 flip twice restores
    for (int i = 0; i < DW; i++) begin
      logic [RW-1:0] m;
      int a = i % WORDS;
      m = (RW'(1) << i) | (RW'(1) << (DW + (i % PW)));
      do_op(2'd2, a, '0, m, 1'b0);
      check("R9", "flip no response", {62'd0, r_rsp, r_det}, 64'd0);
      do_op(2'd3, a, '0, '0, 1'b0);
      check("R3", "paired flip undetected", 64'(r_det), 64'd0);
      check("R3", "paired flip data", r_data, shadow[a] ^ (64'd1 << i));
      do_op(2'd2, a, '0, m, 1'b0);
      clean_read("R9", a);
    end

    // R4, R6, R7: every burst of 1..8 bits at every position
    for (int len = 1; len <= PW; len++) begin
      for (int s = 0; s + len <= RW; s++) begin
        logic [RW-1:0] m;
        int a = (len + s) % WORDS;
        bit hold = (len == 3 && s == 5);
        m = ((RW'(1) << len) - RW'(1)) << s;
        do_op(2'd2, a, '0, m, 1'b0);
        do_op(2'd0, a, shadow[a], '0, hold);
        check("R4", "burst detected", 64'(r_det), 64'd1);
        check("R6", "rebuilt data", r_data, shadow[a]);
        check("R7", "busy cycles", 64'(r_busy), 64'(WORDS + 2));
        check("R8", "no uncorrectable", 64'(r_unc), 64'd0);
        clean_read("R6", a);
        if (hold) for (int b = 0; b < WORDS; b++) clean_read("R7", b);
      end
    end

    // R8: two corrupted rows
    do_op(2'd2, 1, '0, RW'(1), 1'b0);
    do_op(2'd2, 2, '0, RW'(1) << 9, 1'b0);
    do_op(2'd0, 1, '0, '0, 1'b0);
    check("R8", "uncorrectable flagged", {62'd0, r_rsp, r_unc}, 64'd3);
    do_op(2'd0, 1, '0, '0, 1'b0);
    check("R8", "row not written back", 64'(r_det), 64'd1);
    do_op(2'd2, 1, '0, RW'(1), 1'b0);
    do_op(2'd2, 2, '0, RW'(1) << 9, 1'b0);
    clean_read("R8", 1);
    clean_read("R8", 2);

    // R6 after fresh writes: the column row still rebuilds
    shadow[4] = 64'hDEAD_BEEF_0BAD_F00D;
    do_op(2'd1, 4, shadow[4], '0, 1'b0);
    do_op(2'd2, 4, '0, RW'(8'hFF) << 60, 1'b0);
    do_op(2'd0, 4, '0, '0, 1'b0);
    check("R6", "rebuild after write", r_data, shadow[4]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule